// File: doc/BRIEF.md
# PS/2 Host-to-Device Byte Transmitter

This block sends one byte from a host controller to a PS/2 device, such as a keyboard or a mouse. A one-cycle start strobe latches the byte. The block then pulls the device clock line low for a programmable hold time. This suspends anything the device was sending. Next it pulls the data line low while the clock is still held. That low data level is both the request to send and the start bit.

After that the block lets go of the clock. The device now supplies the clock. On each falling device edge the block presents the next frame bit: the eight data bits least significant first, then an odd parity bit, then a released (high) stop bit. When the device has clocked through the whole frame, the block pulls the clock low again and pulses done. The clock stays held low until the next start, so the receive logic can be armed for the device's reply without losing bits.

Each line is open-drain. An enable output of 1 drives that line low, and 0 lets it float high. The clock level fed back in must already be synchronised to the system clock. Every start also pulses an abort output, which cancels any reception in progress. If the device never finishes clocking the frame, the block raises a timeout flag and releases both lines.

Top module: `ps2_host_tx`

## Requirements
- R1: After reset both line enables are 0, and busy, done, timeout and rx_abort are all 0.
- R2: A start accepted while not busy pulses rx_abort for exactly one cycle. It then holds ps2_clk_oe=1 and ps2_dat_oe=0 for exactly INHIBIT_CYCLES cycles.
- R3: After the hold time, ps2_dat_oe=1 and ps2_clk_oe=1 together for exactly REQ_CYCLES cycles. Then the clock is released while ps2_dat_oe stays 1, which is a low start bit.
- R4: The data bits appear on the line least significant first. Each new bit appears after a falling edge of ps2_clk_in, and the data enable changes only while ps2_clk_in is low.
- R5: The bit after the eighth data bit is the parity bit. It makes the count of ones over the data and parity odd.
- R6: The bit after parity is the stop bit. It is a released (high) data line.
- R7: On the eleventh falling device-clock edge, ps2_clk_oe goes to 1, ps2_dat_oe goes to 0, busy drops and done pulses for one cycle. The clock then stays held low until the next start.
- R8: A start that arrives while busy is ignored. The frame in progress keeps its byte, and no rx_abort is produced.
- R9: If the frame is not finished within TIMEOUT_CYCLES cycles of the clock release, timeout is set and both enables go to 0. Timeout stays set until the next accepted start clears it.
- R10: A start that arrives while the clock is held after a finished frame is accepted. It begins a new frame as described in R2.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | One-cycle request to send tx_byte |
| tx_byte | input | 8 | Byte to transmit |
| ps2_clk_in | input | 1 | Synchronised level of the PS/2 clock line |
| ps2_clk_oe | output | 1 | 1 drives the PS/2 clock line low |
| ps2_dat_oe | output | 1 | 1 drives the PS/2 data line low |
| busy | output | 1 | Hold, request or shift phase in progress |
| done | output | 1 | One-cycle pulse when the frame is finished |
| timeout | output | 1 | Sticky flag: the device did not finish the frame in time |
| rx_abort | output | 1 | One-cycle pulse on an accepted start |

## Verification
The bench builds the block with INHIBIT_CYCLES=20, REQ_CYCLES=2 and TIMEOUT_CYCLES=3000. The short hold and request windows let the bench count those phases exactly, cycle by cycle, in every frame. The small timeout limit puts a stalled device within a few thousand cycles. This covers both the release of the lines on timeout and the clearing of the flag by the next start. Parity corner bytes are sent back to back from the clock-held state, and one frame takes a second start in the middle of the frame.

// File: rtl/ps2_host_tx.sv
module ps2_host_tx #(
  parameter int INHIBIT_CYCLES = 10000,
  parameter int REQ_CYCLES     = 200,
  parameter int TIMEOUT_CYCLES = 1500000
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       start,
  input  logic [7:0] tx_byte,
  input  logic       ps2_clk_in,
  output logic       ps2_clk_oe,
  output logic       ps2_dat_oe,
  output logic       busy,
  output logic       done,
  output logic       timeout,
  output logic       rx_abort
);
  localparam int MAXC = (INHIBIT_CYCLES > TIMEOUT_CYCLES) ? INHIBIT_CYCLES : TIMEOUT_CYCLES;
  localparam int CW   = $clog2(MAXC + 1);
  localparam int LAST_BIT = 10;

  typedef enum logic [2:0] {S_IDLE, S_INHIB, S_REQ, S_SHIFT, S_HOLD} st_t;

  st_t           st;
  logic [CW-1:0] cnt;
  logic [8:0]    sh;
  logic          cur;
  logic [3:0]    nbit;
  logic          clk_q;
  logic          fall;

  assign fall       = clk_q & ~ps2_clk_in;
  assign busy       = (st == S_INHIB) || (st == S_REQ) || (st == S_SHIFT);
  assign ps2_clk_oe = (st == S_INHIB) || (st == S_REQ) || (st == S_HOLD);
  assign ps2_dat_oe = (st == S_REQ) || ((st == S_SHIFT) && !cur);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st       <= S_IDLE;
      cnt      <= '0;
      sh       <= '1;
      cur      <= 1'b1;
      nbit     <= '0;
      clk_q    <= 1'b1;
      done     <= 1'b0;
      timeout  <= 1'b0;
      rx_abort <= 1'b0;
    end else begin
      clk_q    <= ps2_clk_in;
      done     <= 1'b0;
      rx_abort <= 1'b0;
      case (st)
        S_IDLE, S_HOLD: begin
          if (start) begin
            st       <= S_INHIB;
            cnt      <= '0;
            sh       <= {~^tx_byte, tx_byte};
            cur      <= 1'b0;
            nbit     <= '0;
            timeout  <= 1'b0;
            rx_abort <= 1'b1;
          end
        end
        S_INHIB: begin
          if (cnt == CW'(INHIBIT_CYCLES - 1)) begin
            st  <= S_REQ;
            cnt <= '0;
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
        S_REQ: begin
          if (cnt == CW'(REQ_CYCLES - 1)) begin
            st  <= S_SHIFT;
            cnt <= '0;
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
        S_SHIFT: begin
          if (fall) begin
            if (nbit == 4'(LAST_BIT)) begin
              st   <= S_HOLD;
              done <= 1'b1;
            end else begin
              cur  <= sh[0];
              sh   <= {1'b1, sh[8:1]};
              nbit <= nbit + 1'b1;
            end
          end else if (cnt == CW'(TIMEOUT_CYCLES - 1)) begin
            st      <= S_IDLE;
            timeout <= 1'b1;
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
        default: st <= S_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/ps2_host_tx_chk.sv
module ps2_host_tx_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       start,
  input logic [7:0] tx_byte,
  input logic       ps2_clk_in,
  input logic       ps2_clk_oe,
  input logic       ps2_dat_oe,
  input logic       busy,
  input logic       done,
  input logic       timeout,
  input logic       rx_abort
);
  logic unused_ok;
  assign unused_ok = ^tx_byte;

  assert_abort_entry_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (start && !busy) |=> (rx_abort && ps2_clk_oe && !ps2_dat_oe));

  assert_abort_pulse_R2: assert property (@(posedge clk) disable iff (!rst_n)
    rx_abort |=> !rx_abort);

  assert_start_bit_R3: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(ps2_clk_oe) && busy) |-> ps2_dat_oe);

  assert_dat_on_low_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && $past(busy) && !ps2_clk_oe && !$past(ps2_clk_oe) && (ps2_dat_oe != $past(ps2_dat_oe)))
      |-> !$past(ps2_clk_in));

  assert_done_pulse_R7: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  assert_done_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (ps2_clk_oe && !ps2_dat_oe && !busy));

  assert_busy_no_abort_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (start && busy) |=> !rx_abort);

  assert_timeout_release_R9: assert property (@(posedge clk) disable iff (!rst_n)
    timeout |-> (!ps2_clk_oe && !ps2_dat_oe && !busy));

  assert_flags_excl_R9: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({done, timeout}));
endmodule

bind ps2_host_tx ps2_host_tx_chk u_chk (.*);

// File: tb/sim_ps2_host_tx.sv
module sim_ps2_host_tx;
  localparam int INH = 20;
  localparam int REQ = 2;
  localparam int TOC = 3000;
  localparam int NV  = 6;
  localparam logic [8:0] VEC [NV] = '{
    {8'h00, 1'b1}, {8'hFF, 1'b1}, {8'hA5, 1'b1},
    {8'h01, 1'b0}, {8'h7F, 1'b0}, {8'hED, 1'b1}
  };

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start = 1'b0;
  logic [7:0] tx_byte = 8'h00;
  logic dev_clk = 1'b1;
  logic ps2_clk_in, ps2_clk_oe, ps2_dat_oe, busy, done, timeout, rx_abort;
  int checks = 0;
  int fails = 0;
  int done_cnt = 0;
  int abort_cnt = 0;
  logic [10:0] got;

  always #5 clk = ~clk;
  assign ps2_clk_in = ps2_clk_oe ? 1'b0 : dev_clk;

  ps2_host_tx #(.INHIBIT_CYCLES(INH), .REQ_CYCLES(REQ), .TIMEOUT_CYCLES(TOC)) u0 (
    .clk(clk), .rst_n(rst_n), .start(start), .tx_byte(tx_byte),
    .ps2_clk_in(ps2_clk_in), .ps2_clk_oe(ps2_clk_oe), .ps2_dat_oe(ps2_dat_oe),
    .busy(busy), .done(done), .timeout(timeout), .rx_abort(rx_abort));

  always @(posedge clk) begin
    if (done) done_cnt <= done_cnt + 1;
    if (rx_abort) abort_cnt <= abort_cnt + 1;
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic begin_tx(input logic [7:0] b);
    int n;
    int a0;
    a0 = abort_cnt;
    @(negedge clk); start = 1'b1; tx_byte = b;
    @(negedge clk); start = 1'b0; tx_byte = ~b;
    chk(rx_abort == 1'b1 && timeout == 1'b0, "R2/R10 abort pulse", int'(rx_abort), 1);
    n = 0;
    while (ps2_clk_oe && !ps2_dat_oe && n < 1000) begin n++; @(negedge clk); end
    chk(n == INH, "R2 inhibit length", n, INH);
    chk(abort_cnt == a0 + 1, "R2 single abort", abort_cnt - a0, 1);
    n = 0;
    while (ps2_clk_oe && ps2_dat_oe && n < 1000) begin n++; @(negedge clk); end
    chk(n == REQ, "R3 request length", n, REQ);
    chk(!ps2_clk_oe && ps2_dat_oe, "R3 start bit low", int'(ps2_dat_oe), 1);
  endtask

  task automatic dev_clock(input bit mid_start, input logic [7:0] other);
    repeat (5) @(negedge clk);
    for (int i = 1; i <= 11; i++) begin
      dev_clk = 1'b0;
      repeat (5) @(negedge clk);
      got[i-1] = ~ps2_dat_oe;
      dev_clk = 1'b1;
      if (mid_start && i == 4) begin
        start = 1'b1; tx_byte = other;
        @(negedge clk); start = 1'b0;
        repeat (4) @(negedge clk);
      end else begin
        repeat (5) @(negedge clk);
      end
    end
  endtask

  task automatic frame(input logic [8:0] v, input bit mid_start);
    int d0;
    int a0;
    begin_tx(v[8:1]);
    d0 = done_cnt;
    a0 = abort_cnt;
    dev_clock(mid_start, 8'h3C);
    chk(got[7:0] == v[8:1], "R4 data LSB first", int'(got[7:0]), int'(v[8:1]));
    chk(got[8] == v[0], "R5 odd parity", int'(got[8]), int'(v[0]));
    chk(got[9] == 1'b1, "R6 stop high", int'(got[9]), 1);
    chk(done_cnt == d0 + 1, "R7 done pulse", done_cnt - d0, 1);
    chk(ps2_clk_oe && !ps2_dat_oe && !busy, "R7 clock held", int'(ps2_clk_oe), 1);
    if (mid_start) chk(abort_cnt == a0, "R8 start ignored", abort_cnt - a0, 0);
    repeat (20) @(negedge clk);
    chk(ps2_clk_oe == 1'b1, "R7 hold persists", int'(ps2_clk_oe), 1);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual %0d expected %0d", 200000, 0);
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(!ps2_clk_oe && !ps2_dat_oe, "R1 lines released", int'(ps2_clk_oe), 0);
    chk(!busy && !done && !timeout && !rx_abort, "R1 flags clear", int'(busy), 0);

    for (int k = 0; k < NV; k++) frame(VEC[k], 1'b0);

    frame({8'h96, 1'b1}, 1'b1);

    begin_tx(8'h55);
    repeat (TOC - 10) @(negedge clk);
    chk(timeout == 1'b0 && busy, "R9 no early timeout", int'(timeout), 0);
    repeat (20) @(negedge clk);
    chk(timeout == 1'b1, "R9 timeout set", int'(timeout), 1);
    chk(!ps2_clk_oe && !ps2_dat_oe && !busy, "R9 lines released", int'(ps2_clk_oe), 0);
    repeat (10) @(negedge clk);
    chk(timeout == 1'b1, "R9 timeout sticky", int'(timeout), 1);
    frame({8'h80, 1'b0}, 1'b0);
    chk(timeout == 1'b0, "R9 cleared by start", int'(timeout), 0);

    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule